// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a single-channel voltage-output DAC. It listens on a write-only three-wire serial link. The link has an active-low frame select, a serial clock and a data line. The block assembles 16-bit command words, most significant bit first, sampling the data line on each falling edge of the serial clock. The serial lines are asynchronous to the block, so they are brought into the system clock domain through two-flop synchronizers, and the edges are detected there.

The top two bits of each word choose the output-stage condition. The four choices are active output, pulldown to ground through 1 kΩ, pulldown through 100 kΩ, and high impedance. The bits below them carry a left-justified DAC code. A frame is valid once 16 falling clock edges have been seen while the frame select is low. A valid frame updates the held code and mode registers and raises a one-cycle strobe. A frame whose select rises early is thrown away. A power-down command leaves the held code untouched, so the output returns to its previous level when the output is enabled again.

Top module: `serial_dac_rx`

## Requirements
- R1: While reset is high and in the cycle after it, `code_o` is all zeros, `mode_o` is 2'b00 (active), and `pd_1k_o`, `pd_100k_o`, `hiz_o` and `upd_o` are low.
- R2: A frame is the span from a falling edge of `cs_n_i` until `cs_n_i` rises. When the 16th falling edge of `sclk_i` in a frame has been sampled, the word built MSB-first from `sdi_i` takes effect and `upd_o` is high for exactly one system clock cycle.
- R3: If `cs_n_i` rises before the 16th falling edge, the partial word is discarded: `code_o` and `mode_o` keep their values and `upd_o` stays low. The next frame is assembled from an empty shift register.
- R4: Word bits [15:14] select the mode. 00 drives no control output, 01 raises only `pd_1k_o`, 10 raises only `pd_100k_o`, and 11 raises only `hiz_o`. At most one of the three is high at any time.
- R5: A valid frame whose bits [15:14] are not 00 updates `mode_o` but leaves `code_o` unchanged. A later frame with bits 00 loads its own code.
- R6: Falling edges of `sclk_i` after the 16th in the same frame cause no further update and no further `upd_o` pulse.
- R7: After a valid frame, a new frame begins only on a fresh falling edge of `cs_n_i`. Clock edges sent while `cs_n_i` stays low have no effect.
- R8: For a CODE_W-bit code, `code_o` takes word bits [13:14-CODE_W]. The word bits below that field have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low frame select (asynchronous) |
| sclk_i | input | 1 | Serial clock; data sampled on its falling edge (asynchronous) |
| sdi_i | input | 1 | Serial data, MSB first (asynchronous) |
| code_o | output | CODE_W | Held DAC code |
| mode_o | output | 2 | Held mode: 00 active, 01 1 kΩ pulldown, 10 100 kΩ pulldown, 11 high impedance |
| pd_1k_o | output | 1 | Output stage tied to ground through 1 kΩ |
| pd_100k_o | output | 1 | Output stage tied to ground through 100 kΩ |
| hiz_o | output | 1 | Output stage left high impedance |
| upd_o | output | 1 | One-cycle strobe after a valid frame |

## Verification
The assertions check several properties on every cycle. The bit counter never passes the word length, and a completed word only appears when the frame select was low. Code and mode change only on an accepted word, and a power-down update never moves the code. The termination controls are one-hot or idle, and the strobe never lasts longer than one cycle. Other behaviour needs whole serial sequences and is shown by the bench's scenarios: the MSB-first bit order, the position of the code field, discarding frames aborted at every possible bit count, ignoring surplus clock edges, and refusing a second word without a fresh select edge.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACTIVE  = 2'b00,
    MODE_PD_1K   = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_HIZ     = 2'b11
  } out_mode_e;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/dacrx_shift.sv
module dacrx_shift #(
  parameter int WORD_W = 16,
  parameter int KEEP_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              word_vld,
  output logic [KEEP_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              cs_d, sclk_d, open_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] next_sh;
  logic [CNT_W-1:0]  cnt_q;
  logic              cs_fall, sclk_fall;

  assign cs_fall   = cs_d & ~cs_n;
  assign sclk_fall = sclk_d & ~sclk;
  assign next_sh   = {sh_q[WORD_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d     <= 1'b1;
      sclk_d   <= 1'b1;
      open_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      cs_d     <= cs_n;
      sclk_d   <= sclk;
      word_vld <= 1'b0;
      if (cs_n) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
        sh_q   <= '0;
      end else if (cs_fall) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
        sh_q   <= '0;
      end else if (open_q && sclk_fall && cnt_q != FULL) begin
        sh_q  <= next_sh;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          word_vld <= 1'b1;
          word     <= next_sh[WORD_W-1 -: KEEP_W];
        end
      end
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= FULL);

  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !open_q |-> (cnt_q == '0 && sh_q == '0));

  // R2
  vld_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> !$past(cs_n));

  // R7
  vld_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> cnt_q == FULL);
endmodule

// File: rtl/dacrx_regs.sv
module dacrx_regs
  import dacrx_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     word_vld,
  input  logic [CODE_W+MODE_W-1:0] word,
  output logic [CODE_W-1:0]        code_o,
  output logic [MODE_W-1:0]        mode_o,
  output logic                     pd_1k_o,
  output logic                     pd_100k_o,
  output logic                     hiz_o,
  output logic                     upd_o
);
  localparam int KEEP_W = CODE_W + MODE_W;

  out_mode_e         mode_q;
  logic [CODE_W-1:0] code_q;
  out_mode_e         new_mode;

  assign new_mode = out_mode_e'(word[KEEP_W-1 -: MODE_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_ACTIVE;
      code_q    <= '0;
      pd_1k_o   <= 1'b0;
      pd_100k_o <= 1'b0;
      hiz_o     <= 1'b0;
      upd_o     <= 1'b0;
    end else begin
      upd_o <= word_vld;
      if (word_vld) begin
        mode_q    <= new_mode;
        pd_1k_o   <= (new_mode == MODE_PD_1K);
        pd_100k_o <= (new_mode == MODE_PD_100K);
        hiz_o     <= (new_mode == MODE_HIZ);
        if (new_mode == MODE_ACTIVE) code_q <= word[CODE_W-1:0];
      end
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (code_q == '0 && mode_q == MODE_ACTIVE && !upd_o));

  // R4
  term_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pd_1k_o, pd_100k_o, hiz_o}));

  // R4
  active_no_term_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == MODE_ACTIVE |-> !(pd_1k_o || pd_100k_o || hiz_o));

  // R5
  pd_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_o && mode_q != MODE_ACTIVE) |-> $stable(code_q));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> ($stable(code_q) && $stable(mode_q)));

  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    upd_o |=> !upd_o);
endmodule

// File: rtl/serial_dac_rx.sv
module serial_dac_rx
  import dacrx_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [1:0]        mode_o,
  output logic              pd_1k_o,
  output logic              pd_100k_o,
  output logic              hiz_o,
  output logic              upd_o
);
  localparam int KEEP_W = CODE_W + MODE_W;

  logic [2:0]        sync_q;
  logic              word_vld;
  logic [KEEP_W-1:0] word;

  dacrx_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n_i, sclk_i, sdi_i}),
    .q_o (sync_q)
  );

  dacrx_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (sync_q[2]),
    .sclk     (sync_q[1]),
    .sdi      (sync_q[0]),
    .word_vld (word_vld),
    .word     (word)
  );

  dacrx_regs #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .word_vld  (word_vld),
    .word      (word),
    .code_o    (code_o),
    .mode_o    (mode_o),
    .pd_1k_o   (pd_1k_o),
    .pd_100k_o (pd_100k_o),
    .hiz_o     (hiz_o),
    .upd_o     (upd_o)
  );
endmodule

// File: tb/tb_serial_dac_rx.sv
module tb_serial_dac_rx;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [CW-1:0] code_o;
  logic [1:0] mode_o;
  logic pd_1k_o, pd_100k_o, hiz_o, upd_o;

  int checks = 0, errors = 0, upd_cnt = 0;
  int exp_upd = 0;
  logic [CW-1:0] exp_code = '0;
  logic [1:0] exp_mode = 2'b00;

  always #10 clk = ~clk;

  serial_dac_rx #(.CODE_W(CW)) dut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_o(code_o), .mode_o(mode_o), .pd_1k_o(pd_1k_o),
    .pd_100k_o(pd_100k_o), .hiz_o(hiz_o), .upd_o(upd_o)
  );

  always @(negedge clk) if (!rst && upd_o) upd_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bits(input logic [15:0] w, input int nedges);
    for (int i = 0; i < nedges; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(4);
      sclk = 1'b1;
    end
    wait_cyc(4);
  endtask

  task automatic send(input logic [15:0] w, input int nedges);
    cs_n = 1'b0;
    wait_cyc(4);
    clock_bits(w, nedges);
    cs_n = 1'b1;
    wait_cyc(8);
  endtask

  function automatic void model(input logic [15:0] w);
    exp_mode = w[15:14];
    if (w[15:14] == 2'b00) exp_code = w[13 -: CW];
    exp_upd++;
  endfunction

  task automatic check_state(input string req);
    chk({req, " code"}, int'(code_o), int'(exp_code));
    chk({req, " mode"}, int'(mode_o), int'(exp_mode));
    chk({req, " R4 terms"}, int'({pd_1k_o, pd_100k_o, hiz_o}),
        int'({exp_mode == 2'b01, exp_mode == 2'b10, exp_mode == 2'b11}));
    chk({req, " strobes"}, upd_cnt, exp_upd);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    // R1: state during reset and just after it
    check_state("R1");
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 post");

    // R2 R4 R5 R8: sweep every mode over many codes, with junk in the low bits
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] w;
        w = {2'(m), 12'((k * 1237 + m * 311) & 12'hFFF), 2'(k)};
        send(w, 16);
        model(w);
        check_state("R2 R5 R8 sweep");
      end
      send({2'b00, 12'((m * 977 + 5) & 12'hFFF), 2'b11}, 16);
      model({2'b00, 12'((m * 977 + 5) & 12'hFFF), 2'b11});
      check_state("R5 restore");
    end

    // R3: abort after every possible number of edges below 16
    for (int n = 0; n < 16; n++) begin
      send({2'b11, 12'hA5A ^ 12'(n), 2'b00}, n);
      check_state("R3 abort");
    end
    send(16'h2BCD, 16);
    model(16'h2BCD);
    check_state("R3 after abort");

    // R6: surplus edges in one frame
    send(16'h1234, 21);
    model(16'h1234);
    check_state("R6 extra edges");

    // R7: second word without a fresh select edge
    cs_n = 1'b0;
    wait_cyc(4);
    clock_bits(16'h0ABC, 16);
    model(16'h0ABC);
    clock_bits(16'hC777, 16);
    cs_n = 1'b1;
    wait_cyc(8);
    check_state("R7 no reframe");

    // R5: explicit hold through power-down and restore
    send({2'b10, 12'hFFF, 2'b00}, 16);
    model({2'b10, 12'hFFF, 2'b00});
    check_state("R5 pd hold");
    send({2'b00, 12'h001, 2'b10}, 16);
    model({2'b00, 12'h001, 2'b10});
    check_state("R5 R8 reload");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule